// File: doc/BRIEF.md
# Banked Data Memory Access Unit

This block holds a 4096-byte data store behind an 8-bit accumulator (W) and runs a small set of data-move instruction words against it. It keeps a 4-bit bank register and W. Each 16-bit word that arrives with `in_valid` is decoded and executed in the cycle it is accepted. The operations are: load the bank register from a literal, store W to a file location, move a file location into W or back onto itself, and a two-word copy between any two locations.

Single-word operations name their location with an 8-bit field and an access bit. With the access bit set, the bank register supplies the upper four address bits. With it clear, the bank register is ignored and the field selects from a split window: the lowest 128 bytes and the highest 128 bytes of the store. The two-word copy carries full 12-bit source and destination addresses. Between its two words the unit is busy.

The arithmetic unit that sits beside this block also writes W. It does so through a plain write port. That port yields to a move-file instruction accepted in the same cycle.

Top module: `bank_mem_unit`

## Requirements
- R1: While reset is asserted, and until the first instruction afterwards, W, the bank register, Z, busy, done and illegal all read 0.
- R2: A word of the form 0x010k sets the bank register to k. No other accepted word changes the bank register.
- R3: A word with upper byte 0110 111a (bits 15..9 = 0110111, bit 8 = a) writes W to the effective address of its low 8-bit field. W is unchanged.
- R4: With the access bit a = 1, the effective address is the bank register in bits 11..8 and the field in bits 7..0. For example, bank 1 with field 0x70 gives 0x170.
- R5: With a = 0, the bank register is ignored. Fields 0x00–0x7F address 0x000–0x07F, and fields 0x80–0xFF address 0xF80–0xFFF.
- R6: A word with upper byte 0101 00da (bits 15..10 = 010100, bit 9 = d, bit 8 = a) and d = 0 loads W from the effective address. Z becomes 1 exactly when the loaded byte is 0.
- R7: The same word with d = 1 writes the addressed byte back to its own location. W and Z are unchanged.
- R8: A word 0xCsss followed by a word 0xFddd copies byte sss to ddd. The bank register plays no part. After the first word, busy is 1 and done is 0.
- R9: If the word after 0xCsss does not have 0xF in bits 15..12, illegal pulses with done. Nothing is written, the word is not executed as an instruction, and the unit returns to idle.
- R10: Only a move-file to W changes Z. Store, bank load, copy, move-back and unrecognised words leave Z unchanged.
- R11: An unrecognised first word changes no state and still pulses done.
- R12: done is 1 in the cycle after every accepted word that completes an instruction, and 0 otherwise.
- R13: The external W write port loads W from `w_wr_data`. A move-file to W accepted in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 16 | Instruction word |
| w_wr_en | input | 1 | External write of W |
| w_wr_data | input | 8 | Value for the external W write |
| w_o | output | 8 | Accumulator W |
| bank_o | output | 4 | Bank register |
| z_o | output | 1 | Zero flag from the last move-file to W |
| busy_o | output | 1 | Waiting for the second word of a copy |
| done_o | output | 1 | Instruction completed in the previous cycle |
| illegal_o | output | 1 | Copy aborted on a bad second word |

## Verification
The assertions assume that every word seen in the busy state is meant as the second word of a copy. They also assume the external W port is either idle when a store is accepted, or that a W change in that case is intended. The bench issues each instruction as a one-cycle valid pulse and separates it from the next by an idle cycle. It drives the W port only outside those pulses, except in the one case that tests precedence. Memory is never read before the bench has written it, so every expected byte is defined.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 12;
  localparam int FIELD_W = 8;
  localparam int BANK_W  = ADDR_W - FIELD_W;
  localparam int WORD_W  = 16;
  localparam int NIB_W   = WORD_W - ADDR_W;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SETBANK,
    OP_STORE,
    OP_MOVE,
    OP_COPY_HEAD
  } op_e;

  typedef struct packed {
    op_e                 op;
    logic                acc_bit;
    logic                dest_f;
    logic [FIELD_W-1:0]  field;
    logic [BANK_W-1:0]   lit;
    logic [ADDR_W-1:0]   full_addr;
  } dec_t;

  typedef enum logic {
    ST_IDLE,
    ST_TAIL
  } state_e;
endpackage

// File: rtl/bmu_rst_sync.sv
module bmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec,
  output logic              is_tail
);
  localparam logic [NIB_W-1:0] HEAD_NIB = 4'hC;
  localparam logic [NIB_W-1:0] TAIL_NIB = 4'hF;

  always_comb begin
    dec.acc_bit   = word[FIELD_W];
    dec.dest_f    = word[FIELD_W+1];
    dec.field     = word[FIELD_W-1:0];
    dec.lit       = word[BANK_W-1:0];
    dec.full_addr = word[ADDR_W-1:0];
    if (word[WORD_W-1:BANK_W] == 12'h010)
      dec.op = OP_SETBANK;
    else if (word[WORD_W-1:FIELD_W+1] == 7'b0110111)
      dec.op = OP_STORE;
    else if (word[WORD_W-1:FIELD_W+2] == 6'b010100)
      dec.op = OP_MOVE;
    else if (word[WORD_W-1:ADDR_W] == HEAD_NIB)
      dec.op = OP_COPY_HEAD;
    else
      dec.op = OP_NONE;
  end

  assign is_tail = (word[WORD_W-1:ADDR_W] == TAIL_NIB);
endmodule

// File: rtl/bmu_ea.sv
module bmu_ea
  import bmu_pkg::*;
(
  input  logic [BANK_W-1:0]  bank,
  input  logic               acc_bit,
  input  logic [FIELD_W-1:0] field,
  output logic [ADDR_W-1:0]  ea
);
  logic [BANK_W-1:0] win_hi;

  // Split window: the field's top bit picks the lowest or highest page.
  assign win_hi = {BANK_W{field[FIELD_W-1]}};

  always_comb begin
    if (acc_bit) ea = {bank, field};
    else         ea = {win_hi, field};
  end
endmodule

// File: rtl/bmu_regfile.sv
module bmu_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/bank_mem_unit.sv
module bank_mem_unit
  import bmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              w_wr_en,
  input  logic [DATA_W-1:0] w_wr_data,
  output logic [DATA_W-1:0] w_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              z_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o
);
  logic rst_ns;

  state_e             state_q, state_d;
  logic [BANK_W-1:0]  bank_q, bank_d;
  logic [DATA_W-1:0]  w_q, w_d;
  logic               z_q, z_d;
  logic [ADDR_W-1:0]  src_q, src_d;
  logic               done_q, done_d;
  logic               ill_q, ill_d;
  logic               bank_en, w_en, z_en, src_en;
  logic               w_by_instr;

  dec_t               dec;
  logic               is_tail;
  logic [ADDR_W-1:0]  ea;
  logic [ADDR_W-1:0]  rd_addr;
  logic [DATA_W-1:0]  rd_data;
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_waddr;
  logic [DATA_W-1:0]  mem_wdata;

  bmu_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  bmu_decode dec_i (
    .word    (in_word),
    .dec     (dec),
    .is_tail (is_tail)
  );

  bmu_ea ea_i (
    .bank    (bank_q),
    .acc_bit (dec.acc_bit),
    .field   (dec.field),
    .ea      (ea)
  );

  assign rd_addr = (state_q == ST_TAIL) ? src_q : ea;

  bmu_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rf_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    bank_d     = bank_q;
    w_d        = w_q;
    z_d        = z_q;
    src_d      = src_q;
    done_d     = 1'b0;
    ill_d      = 1'b0;
    bank_en    = 1'b0;
    w_en       = 1'b0;
    z_en       = 1'b0;
    src_en     = 1'b0;
    w_by_instr = 1'b0;
    mem_we     = 1'b0;
    mem_waddr  = ea;
    mem_wdata  = w_q;

    if (in_valid) begin
      if (state_q == ST_TAIL) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (is_tail) begin
          mem_we    = 1'b1;
          mem_waddr = in_word[ADDR_W-1:0];
          mem_wdata = rd_data;
        end else begin
          ill_d = 1'b1;
        end
      end else begin
        case (dec.op)
          OP_SETBANK: begin
            bank_d  = dec.lit;
            bank_en = 1'b1;
            done_d  = 1'b1;
          end
          OP_STORE: begin
            mem_we = 1'b1;
            done_d = 1'b1;
          end
          OP_MOVE: begin
            done_d = 1'b1;
            if (dec.dest_f) begin
              mem_we    = 1'b1;
              mem_wdata = rd_data;
            end else begin
              w_d        = rd_data;
              w_en       = 1'b1;
              w_by_instr = 1'b1;
              z_d        = (rd_data == '0);
              z_en       = 1'b1;
            end
          end
          OP_COPY_HEAD: begin
            src_d   = dec.full_addr;
            src_en  = 1'b1;
            state_d = ST_TAIL;
          end
          default: begin
            done_d = 1'b1;
          end
        endcase
      end
    end

    if (w_wr_en && !w_by_instr) begin
      w_d  = w_wr_data;
      w_en = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      w_q     <= '0;
      z_q     <= 1'b0;
      src_q   <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
      if (bank_en) bank_q <= bank_d;
      if (w_en)    w_q    <= w_d;
      if (z_en)    z_q    <= z_d;
      if (src_en)  src_q  <= src_d;
    end
  end

  assign w_o       = w_q;
  assign bank_o    = bank_q;
  assign z_o       = z_q;
  assign busy_o    = (state_q == ST_TAIL);
  assign done_o    = done_q;
  assign illegal_o = ill_q;

  // Assertions
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!(in_valid && state_q == ST_IDLE && dec.op == OP_SETBANK)) |=> $stable(bank_q));

  assert_store_keeps_w_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && state_q == ST_IDLE && dec.op == OP_STORE && !w_wr_en) |=> $stable(w_q));

  assert_head_busy_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && state_q == ST_IDLE && dec.op == OP_COPY_HEAD) |=> (busy_o && !done_o));

  assert_bad_tail_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && state_q == ST_TAIL && !is_tail) |-> !mem_we);

  assert_z_hold_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (!(in_valid && state_q == ST_IDLE && dec.op == OP_MOVE && !dec.dest_f)) |=> $stable(z_q));

  assert_illegal_with_done_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    illegal_o |-> done_o);
endmodule

// File: tb/bank_mem_unit_tb_top.sv
module bank_mem_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_word;
  logic        w_wr_en;
  logic [7:0]  w_wr_data;
  logic [7:0]  w_o;
  logic [3:0]  bank_o;
  logic        z_o;
  logic        busy_o;
  logic        done_o;
  logic        illegal_o;

  int total = 0;
  int bad   = 0;

  logic [7:0] mem_m [4096];
  logic [7:0] exp_w;
  logic [3:0] exp_bank;
  logic       exp_z;

  bank_mem_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .w_wr_en   (w_wr_en),
    .w_wr_data (w_wr_data),
    .w_o       (w_o),
    .bank_o    (bank_o),
    .z_o       (z_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ea_m(input logic [3:0] b, input logic a, input logic [7:0] f);
    if (a) return {b, f};
    return f[7] ? {4'hF, f} : {4'h0, f};
  endfunction

  task automatic issue(input logic [15:0] wd);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = wd;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = '0;
  endtask

  task automatic set_w(input logic [7:0] v);
    @(negedge clk);
    w_wr_en   = 1'b1;
    w_wr_data = v;
    @(negedge clk);
    w_wr_en   = 1'b0;
    exp_w     = v;
  endtask

  task automatic set_bank(input logic [3:0] b);
    issue({12'h010, b});
    exp_bank = b;
    chk("R2 bank", {12'h0, bank_o}, {12'h0, b});
  endtask

  task automatic store(input logic a, input logic [7:0] f);
    issue({7'b0110111, a, f});
    mem_m[ea_m(exp_bank, a, f)] = exp_w;
    chk("R12 store done", {15'h0, done_o}, 16'h1);
    chk("R3 w kept", {8'h0, w_o}, {8'h0, exp_w});
  endtask

  task automatic load(input logic a, input logic [7:0] f);
    issue({6'b010100, 1'b0, a, f});
    exp_w = mem_m[ea_m(exp_bank, a, f)];
    exp_z = (exp_w == 8'h00);
    chk(a ? "R4 R6 load w" : "R5 R6 load w", {8'h0, w_o}, {8'h0, exp_w});
    chk("R6 z", {15'h0, z_o}, {15'h0, exp_z});
  endtask

  task automatic read_addr(input logic [11:0] ad);
    set_bank(ad[11:8]);
    load(1'b1, ad[7:0]);
  endtask

  function automatic logic [7:0] pat(input int b, input int f);
    return 8'((b * 37 + f * 11 + 5) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_word   = '0;
    w_wr_en   = 1'b0;
    w_wr_data = '0;
    exp_w     = '0;
    exp_bank  = '0;
    exp_z     = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 w", {8'h0, w_o}, 16'h0);
    chk("R1 bank", {12'h0, bank_o}, 16'h0);
    chk("R1 flags", {12'h0, z_o, busy_o, done_o, illegal_o}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {4'h0, w_o, bank_o}, 16'h0);
    chk("R1 flags after release", {12'h0, z_o, busy_o, done_o, illegal_o}, 16'h0);

    // Banked fill of the whole store
    for (int b = 0; b < 16; b++) begin
      set_bank(4'(b));
      for (int f = 0; f < 256; f++) begin
        set_w(pat(b, f));
        store(1'b1, 8'(f));
      end
    end
    // Banked read-back of every location
    for (int b = 0; b < 16; b++) begin
      set_bank(4'(b));
      for (int f = 0; f < 256; f++) load(1'b1, 8'(f));
    end
    // Split window reads under an unrelated bank
    set_bank(4'h7);
    for (int f = 0; f < 256; f++) load(1'b0, 8'(f));

    // Split window stores ignore the bank
    set_bank(4'h9);
    set_w(8'hA5);
    store(1'b0, 8'h90);
    set_w(8'h3C);
    store(1'b0, 8'h12);
    read_addr(12'hF90);
    chk("R5 high page", {8'h0, w_o}, 16'h00A5);
    read_addr(12'h012);
    chk("R5 low page", {8'h0, w_o}, 16'h003C);
    read_addr(12'h990);
    chk("R5 bank page untouched", {8'h0, w_o}, {8'h0, pat(9, 8'h90)});

    // Move back onto itself: W and Z kept
    set_w(8'h00);
    store(1'b1, 8'h44);
    load(1'b1, 8'h44);
    chk("R6 zero sets z", {15'h0, z_o}, 16'h1);
    set_w(8'h5A);
    issue({6'b010100, 1'b1, 1'b1, 8'h21});
    chk("R7 w kept", {8'h0, w_o}, 16'h005A);
    chk("R7 z kept", {15'h0, z_o}, 16'h1);
    chk("R12 move done", {15'h0, done_o}, 16'h1);
    load(1'b1, 8'h21);
    chk("R7 byte intact", {8'h0, w_o}, {8'h0, mem_m[{exp_bank, 8'h21}]});
    load(1'b1, 8'h44);

    // Z hold across other operations (z is 1 here)
    set_w(8'h77);
    store(1'b1, 8'h45);
    chk("R10 z after store", {15'h0, z_o}, 16'h1);
    set_bank(4'h3);
    chk("R10 z after bank load", {15'h0, z_o}, 16'h1);

    // Two-word copies, bank register set to an unrelated value
    set_bank(4'hC);
    begin
      logic [11:0] srcs [3];
      logic [11:0] dsts [3];
      srcs[0] = 12'h1A0; dsts[0] = 12'h23F;
      srcs[1] = 12'hF85; dsts[1] = 12'h010;
      srcs[2] = 12'h3FF; dsts[2] = 12'hA00;
      for (int i = 0; i < 3; i++) begin
        set_bank(4'hC);
        issue({4'hC, srcs[i]});
        chk("R8 busy after head", {15'h0, busy_o}, 16'h1);
        chk("R12 no done after head", {15'h0, done_o}, 16'h0);
        issue({4'hF, dsts[i]});
        mem_m[dsts[i]] = mem_m[srcs[i]];
        chk("R8 done after tail", {14'h0, busy_o, done_o}, 16'h1);
        chk("R8 no illegal", {15'h0, illegal_o}, 16'h0);
        chk("R10 z after copy", {15'h0, z_o}, {15'h0, exp_z});
        chk("R2 copy keeps bank", {12'h0, bank_o}, 16'h000C);
        read_addr(dsts[i]);
        chk("R8 copied byte", {8'h0, w_o}, {8'h0, mem_m[srcs[i]]});
      end
    end

    // Bad second word: not executed, nothing written
    set_bank(4'h6);
    issue(16'hC123);
    issue(16'h0105);
    chk("R9 illegal", {14'h0, illegal_o, done_o}, 16'h3);
    chk("R9 idle again", {15'h0, busy_o}, 16'h0);
    chk("R9 word not executed", {12'h0, bank_o}, 16'h0006);
    issue(16'hC200);
    issue(16'h6E05);
    chk("R9 illegal store word", {15'h0, illegal_o}, 16'h1);
    read_addr(12'h005);
    chk("R9 no write", {8'h0, w_o}, {8'h0, mem_m[12'h005]});
    @(negedge clk);
    chk("R12 done drops", {14'h0, done_o, illegal_o}, 16'h0);

    // Unrecognised words
    set_w(8'h81);
    set_bank(4'hB);
    issue(16'h0000);
    chk("R11 done", {15'h0, done_o}, 16'h1);
    chk("R11 state kept", {3'h0, z_o, w_o, bank_o}, {3'h0, exp_z, exp_w, exp_bank});
    issue(16'hFFFF);
    chk("R11 tail nibble idle", {14'h0, busy_o, done_o}, 16'h1);
    chk("R11 state kept 2", {3'h0, z_o, w_o, bank_o}, {3'h0, exp_z, exp_w, exp_bank});

    // External write against a move-to-W in the same cycle
    @(negedge clk);
    in_valid  = 1'b1;
    in_word   = {6'b010100, 1'b0, 1'b1, 8'h33};
    w_wr_en   = 1'b1;
    w_wr_data = 8'hEE;
    @(negedge clk);
    in_valid  = 1'b0;
    w_wr_en   = 1'b0;
    chk("R13 instruction wins", {8'h0, w_o}, {8'h0, mem_m[{4'hB, 8'h33}]});
    set_w(8'hEE);
    chk("R13 port write", {8'h0, w_o}, 16'h00EE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule